// File: doc/BRIEF.md
# RISC Instruction Decoder

This block turns one 32-bit load/store RISC instruction word into the fields and control signals a pipeline's decode stage needs. It is purely combinational: the word goes in, and in the same cycle it yields the register numbers, the shift amount, the raw and extended immediate, the jump target and a control bundle. The bundle carries the ALU operation, the destination register, the extension mode, register-write enable, memory read and write strobes, branch kind, jump kind, a multiply/divide class flag and an illegal-instruction flag.

A zero primary opcode hands the choice of operation to the low six-bit function field. Every other opcode chooses the operation directly. Which field names the destination depends on the format. Register-type words write the third register field. Immediate-type words write the second. The link-and-jump form always writes register 31. A write aimed at register 0 is dropped, because that register always reads as zero. The register file, ALU, memories and program counter are outside this block.

Top module: `riscdec_top`

## Requirements
- R1: The raw fields are always presented, whatever the opcode: rs = bits 25:21, rt = bits 20:16, rd = bits 15:11, shamt = bits 10:6, imm = bits 15:0, target = bits 25:0.
- R2: `fmt_o` is 0 (register type) for opcode 0, 2 (jump type) for opcodes 2 and 3, and 1 (immediate type) for any other opcode.
- R3: With opcode 0, function codes 32, 34, 36, 37 and 42 select ALU codes 0 (add), 1 (sub), 2 (and), 3 (or) and 4 (set-less-than). They write register rd.
- R4: Opcodes 8, 10, 12 and 13 select ALU codes 0, 4, 2 and 3 respectively. They write register rt.
- R5: Opcodes 8, 10, 32, 35, 40, 43, 4, 5 and 7 sign-extend the immediate and set `imm_sign_o`. Every other opcode zero-extends it. `imm_ext_o` holds the extended value.
- R6: Opcodes 35 (word) and 32 (byte) assert `mem_rd_o` and write rt. Opcodes 43 (word) and 40 (byte) assert `mem_wr_o` and write no register. `mem_byte_o` is set for 32 and 40. All four use ALU code 0.
- R7: Opcodes 4, 5 and 7 give `branch_o` = 1 (equal), 2 (not equal) and 3 (greater than zero). They use ALU code 1 and write no register.
- R8: Opcode 2 gives `jump_o` = 1 with no write. Opcode 3 gives `jump_o` = 2, destination 31 and a register write. Function code 8 under opcode 0 gives `jump_o` = 3 with no write.
- R9: Function codes 24 and 26 under opcode 0 set `muldiv_o`, give ALU code 5 (none) and write no register.
- R10: `reg_we_o` is never asserted when `dst_o` is 0. This includes loads and arithmetic aimed at register 0.
- R11: Any opcode, or any function code under opcode 0, that is not listed above sets `illegal_o`. It forces ALU code 5 and drops register write, memory strobes, branch, jump and multiply/divide. The all-zero word counts as illegal.
- R12: `dst_o` is rd for register-type words, rt for immediate-type words, 31 for opcode 3 and 0 for opcode 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| fmt_o | output | 2 | Format: 0 register, 1 immediate, 2 jump |
| rs_o | output | 5 | First source register field |
| rt_o | output | 5 | Second register field |
| rd_o | output | 5 | Third register field |
| shamt_o | output | 5 | Shift amount field |
| imm_o | output | 16 | Raw immediate |
| imm_ext_o | output | 32 | Immediate after sign or zero extension |
| target_o | output | 26 | Jump target field |
| alu_op_o | output | 3 | ALU code (0 add, 1 sub, 2 and, 3 or, 4 slt, 5 none) |
| dst_o | output | 5 | Destination register number |
| imm_sign_o | output | 1 | 1 when the immediate is sign-extended |
| reg_we_o | output | 1 | Register-file write enable |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_byte_o | output | 1 | Byte-sized memory access |
| branch_o | output | 2 | Branch kind (0 none, 1 eq, 2 ne, 3 gtz) |
| jump_o | output | 2 | Jump kind (0 none, 1 absolute, 2 link, 3 register) |
| muldiv_o | output | 1 | Multiply/divide class |
| illegal_o | output | 1 | Unrecognised instruction |

## Verification
Two cases get the most attention. The first is the link jump: it redirects control and also writes register 31, so one word must raise both the jump kind and the write enable. The second is the collision between a load and a destination of register 0: the memory read must still be issued while the register write is dropped. Both cases appear as table vectors, alongside add and load words aimed at register 0. Each vector's full control bundle is compared against a hand-derived expectation. Illegal words are judged by confirming that every side-effect output is low, not only that the flag is set.

// File: rtl/riscdec_pkg.sv
package riscdec_pkg;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned REG_W   = 5;
  localparam int unsigned IMM_W   = 16;
  localparam int unsigned TGT_W   = 26;
  localparam int unsigned CODE_W  = 6;

  // primary opcodes
  localparam logic [CODE_W-1:0] OPC_RTYPE = 6'd0;
  localparam logic [CODE_W-1:0] OPC_JMP   = 6'd2;
  localparam logic [CODE_W-1:0] OPC_JLNK  = 6'd3;
  localparam logic [CODE_W-1:0] OPC_BEQ   = 6'd4;
  localparam logic [CODE_W-1:0] OPC_BNE   = 6'd5;
  localparam logic [CODE_W-1:0] OPC_BGTZ  = 6'd7;
  localparam logic [CODE_W-1:0] OPC_ADDI  = 6'd8;
  localparam logic [CODE_W-1:0] OPC_SLTI  = 6'd10;
  localparam logic [CODE_W-1:0] OPC_ANDI  = 6'd12;
  localparam logic [CODE_W-1:0] OPC_ORI   = 6'd13;
  localparam logic [CODE_W-1:0] OPC_LDB   = 6'd32;
  localparam logic [CODE_W-1:0] OPC_LDW   = 6'd35;
  localparam logic [CODE_W-1:0] OPC_STB   = 6'd40;
  localparam logic [CODE_W-1:0] OPC_STW   = 6'd43;

  // secondary function codes
  localparam logic [CODE_W-1:0] FN_JREG = 6'd8;
  localparam logic [CODE_W-1:0] FN_MUL  = 6'd24;
  localparam logic [CODE_W-1:0] FN_DIV  = 6'd26;
  localparam logic [CODE_W-1:0] FN_ADD  = 6'd32;
  localparam logic [CODE_W-1:0] FN_SUB  = 6'd34;
  localparam logic [CODE_W-1:0] FN_AND  = 6'd36;
  localparam logic [CODE_W-1:0] FN_OR   = 6'd37;
  localparam logic [CODE_W-1:0] FN_SLT  = 6'd42;

  typedef enum logic [1:0] {FMT_REG = 2'd0, FMT_IMM = 2'd1, FMT_JMP = 2'd2} fmt_e;
  typedef enum logic [2:0] {
    ALU_ADD = 3'd0, ALU_SUB = 3'd1, ALU_AND = 3'd2,
    ALU_OR  = 3'd3, ALU_SLT = 3'd4, ALU_NONE = 3'd5
  } alu_e;
  typedef enum logic [1:0] {BR_NONE = 2'd0, BR_EQ = 2'd1, BR_NE = 2'd2, BR_GTZ = 2'd3} br_e;
  typedef enum logic [1:0] {JP_NONE = 2'd0, JP_ABS = 2'd1, JP_LINK = 2'd2, JP_REG = 2'd3} jmp_e;
  typedef enum logic [1:0] {DS_RD = 2'd0, DS_RT = 2'd1, DS_LINK = 2'd2, DS_NONE = 2'd3} dsel_e;

  typedef struct packed {
    alu_e  alu;
    logic  wr;
    dsel_e dsel;
    logic  sgn;
    logic  mrd;
    logic  mwr;
    logic  byt;
    br_e   br;
    jmp_e  jmp;
    logic  md;
    logic  ill;
  } ctrl_t;

  localparam ctrl_t CTRL_ILLEGAL = '{alu: ALU_NONE, wr: 1'b0, dsel: DS_RD, sgn: 1'b0,
                                     mrd: 1'b0, mwr: 1'b0, byt: 1'b0, br: BR_NONE,
                                     jmp: JP_NONE, md: 1'b0, ill: 1'b1};

endpackage

// File: rtl/riscdec_fields.sv
module riscdec_fields
  import riscdec_pkg::*;
(
  input  logic [INSTR_W-1:0] word_i,
  output logic [CODE_W-1:0]  opc_o,
  output logic [CODE_W-1:0]  fn_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   sh_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [TGT_W-1:0]   tgt_o
);
  localparam int unsigned RS_LO = INSTR_W - CODE_W - REG_W;
  localparam int unsigned RT_LO = RS_LO - REG_W;
  localparam int unsigned RD_LO = RT_LO - REG_W;
  localparam int unsigned SH_LO = RD_LO - REG_W;

  always_comb begin
    opc_o = word_i[INSTR_W-1 -: CODE_W];
    rs_o  = word_i[RS_LO +: REG_W];
    rt_o  = word_i[RT_LO +: REG_W];
    rd_o  = word_i[RD_LO +: REG_W];
    sh_o  = word_i[SH_LO +: REG_W];
    fn_o  = word_i[CODE_W-1:0];
    imm_o = word_i[IMM_W-1:0];
    tgt_o = word_i[TGT_W-1:0];
  end
endmodule

// File: rtl/riscdec_opdec.sv
module riscdec_opdec
  import riscdec_pkg::*;
(
  input  logic [CODE_W-1:0] opc_i,
  output ctrl_t             ctrl_o
);
  always_comb begin
    ctrl_o      = CTRL_ILLEGAL;
    ctrl_o.ill  = 1'b0;
    ctrl_o.dsel = DS_RT;
    unique case (opc_i)
      OPC_ADDI: begin ctrl_o.alu = ALU_ADD; ctrl_o.wr = 1'b1; ctrl_o.sgn = 1'b1; end
      OPC_SLTI: begin ctrl_o.alu = ALU_SLT; ctrl_o.wr = 1'b1; ctrl_o.sgn = 1'b1; end
      OPC_ANDI: begin ctrl_o.alu = ALU_AND; ctrl_o.wr = 1'b1; end
      OPC_ORI:  begin ctrl_o.alu = ALU_OR;  ctrl_o.wr = 1'b1; end
      OPC_LDW, OPC_LDB: begin
        ctrl_o.alu = ALU_ADD; ctrl_o.wr = 1'b1; ctrl_o.sgn = 1'b1; ctrl_o.mrd = 1'b1;
        ctrl_o.byt = (opc_i == OPC_LDB);
      end
      OPC_STW, OPC_STB: begin
        ctrl_o.alu = ALU_ADD; ctrl_o.sgn = 1'b1; ctrl_o.mwr = 1'b1;
        ctrl_o.byt = (opc_i == OPC_STB);
      end
      OPC_BEQ:  begin ctrl_o.alu = ALU_SUB; ctrl_o.sgn = 1'b1; ctrl_o.br = BR_EQ;  end
      OPC_BNE:  begin ctrl_o.alu = ALU_SUB; ctrl_o.sgn = 1'b1; ctrl_o.br = BR_NE;  end
      OPC_BGTZ: begin ctrl_o.alu = ALU_SUB; ctrl_o.sgn = 1'b1; ctrl_o.br = BR_GTZ; end
      OPC_JMP:  begin ctrl_o.jmp = JP_ABS; ctrl_o.dsel = DS_NONE; end
      OPC_JLNK: begin ctrl_o.jmp = JP_LINK; ctrl_o.wr = 1'b1; ctrl_o.dsel = DS_LINK; end
      default:  begin ctrl_o.ill = 1'b1; end
    endcase
  end
endmodule

// File: rtl/riscdec_fndec.sv
module riscdec_fndec
  import riscdec_pkg::*;
(
  input  logic [CODE_W-1:0] fn_i,
  output ctrl_t             ctrl_o
);
  always_comb begin
    ctrl_o      = CTRL_ILLEGAL;
    ctrl_o.ill  = 1'b0;
    ctrl_o.dsel = DS_RD;
    unique case (fn_i)
      FN_ADD: begin ctrl_o.alu = ALU_ADD; ctrl_o.wr = 1'b1; end
      FN_SUB: begin ctrl_o.alu = ALU_SUB; ctrl_o.wr = 1'b1; end
      FN_AND: begin ctrl_o.alu = ALU_AND; ctrl_o.wr = 1'b1; end
      FN_OR:  begin ctrl_o.alu = ALU_OR;  ctrl_o.wr = 1'b1; end
      FN_SLT: begin ctrl_o.alu = ALU_SLT; ctrl_o.wr = 1'b1; end
      FN_MUL, FN_DIV: begin ctrl_o.md = 1'b1; end
      FN_JREG: begin ctrl_o.jmp = JP_REG; end
      default: begin ctrl_o.ill = 1'b1; end
    endcase
  end
endmodule

// File: rtl/riscdec_immext.sv
module riscdec_immext #(
  parameter int unsigned IN_W  = 16,
  parameter int unsigned OUT_W = 32
) (
  input  logic [IN_W-1:0]  imm_i,
  input  logic             sgn_i,
  output logic [OUT_W-1:0] ext_o
);
  localparam int unsigned PAD_W = OUT_W - IN_W;
  logic fill;
  always_comb begin
    fill  = sgn_i & imm_i[IN_W-1];
    ext_o = {{PAD_W{fill}}, imm_i};
  end
endmodule

// File: rtl/riscdec_top.sv
module riscdec_top
  import riscdec_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned LINK_REG = 31
) (
  input  logic [INSTR_W-1:0] instr_i,
  output logic [1:0]         fmt_o,
  output logic [REG_W-1:0]   rs_o,
  output logic [REG_W-1:0]   rt_o,
  output logic [REG_W-1:0]   rd_o,
  output logic [REG_W-1:0]   shamt_o,
  output logic [IMM_W-1:0]   imm_o,
  output logic [DATA_W-1:0]  imm_ext_o,
  output logic [TGT_W-1:0]   target_o,
  output logic [2:0]         alu_op_o,
  output logic [REG_W-1:0]   dst_o,
  output logic               imm_sign_o,
  output logic               reg_we_o,
  output logic               mem_rd_o,
  output logic               mem_wr_o,
  output logic               mem_byte_o,
  output logic [1:0]         branch_o,
  output logic [1:0]         jump_o,
  output logic               muldiv_o,
  output logic               illegal_o
);
  localparam logic [REG_W-1:0] LINK_IDX = REG_W'(LINK_REG);

  logic [CODE_W-1:0] opc, fn;
  ctrl_t op_ctrl, fn_ctrl, sel_ctrl, fin_ctrl;
  logic  is_reg;

  riscdec_fields u_fields (
    .word_i(instr_i), .opc_o(opc), .fn_o(fn), .rs_o(rs_o), .rt_o(rt_o),
    .rd_o(rd_o), .sh_o(shamt_o), .imm_o(imm_o), .tgt_o(target_o)
  );

  riscdec_opdec u_opdec (.opc_i(opc), .ctrl_o(op_ctrl));
  riscdec_fndec u_fndec (.fn_i(fn),   .ctrl_o(fn_ctrl));

  always_comb begin
    is_reg   = (opc == OPC_RTYPE);
    sel_ctrl = is_reg ? fn_ctrl : op_ctrl;
    if (is_reg) fmt_o = FMT_REG;
    else if (opc == OPC_JMP || opc == OPC_JLNK) fmt_o = FMT_JMP;
    else fmt_o = FMT_IMM;
  end

  // destination selection by format, then silence illegal and zero-target writes
  always_comb begin
    fin_ctrl = sel_ctrl;
    unique case (sel_ctrl.dsel)
      DS_RD:   dst_o = rd_o;
      DS_RT:   dst_o = rt_o;
      DS_LINK: dst_o = LINK_IDX;
      default: dst_o = '0;
    endcase
    if (sel_ctrl.ill) begin
      fin_ctrl      = CTRL_ILLEGAL;
      fin_ctrl.dsel = sel_ctrl.dsel;
    end
    if (dst_o == '0) fin_ctrl.wr = 1'b0;
  end

  riscdec_immext #(.IN_W(IMM_W), .OUT_W(DATA_W)) u_immext (
    .imm_i(imm_o), .sgn_i(fin_ctrl.sgn), .ext_o(imm_ext_o)
  );

  always_comb begin
    alu_op_o   = fin_ctrl.alu;
    imm_sign_o = fin_ctrl.sgn;
    reg_we_o   = fin_ctrl.wr;
    mem_rd_o   = fin_ctrl.mrd;
    mem_wr_o   = fin_ctrl.mwr;
    mem_byte_o = fin_ctrl.byt;
    branch_o   = fin_ctrl.br;
    jump_o     = fin_ctrl.jmp;
    muldiv_o   = fin_ctrl.md;
    illegal_o  = fin_ctrl.ill;
  end
endmodule

// File: rtl/riscdec_chk.sv
module riscdec_chk (
  input logic [15:0] imm_o,
  input logic [31:0] imm_ext_o,
  input logic [4:0]  dst_o,
  input logic        imm_sign_o,
  input logic        reg_we_o,
  input logic        mem_rd_o,
  input logic        mem_wr_o,
  input logic [1:0]  branch_o,
  input logic [1:0]  jump_o,
  input logic        muldiv_o,
  input logic        illegal_o
);
  always_comb begin
    // R10
    dst_zero_we_chk: assert (!(reg_we_o && dst_o == 5'd0));
    // R11
    illegal_quiet_chk: assert (!illegal_o ||
      (!reg_we_o && !mem_rd_o && !mem_wr_o && branch_o == 2'd0 && jump_o == 2'd0 && !muldiv_o));
    // R8
    link_dst_chk: assert (jump_o != 2'd2 || (dst_o == 5'd31 && reg_we_o));
    // R7
    branch_nowrite_chk: assert (branch_o == 2'd0 || (!reg_we_o && jump_o == 2'd0));
    // R6
    mem_excl_chk: assert (!(mem_rd_o && mem_wr_o));
    // R5
    ext_upper_chk: assert (imm_ext_o[31:16] == ((imm_sign_o && imm_o[15]) ? 16'hFFFF : 16'h0000));
  end
endmodule

bind riscdec_top riscdec_chk u_chk (
  .imm_o(imm_o), .imm_ext_o(imm_ext_o), .dst_o(dst_o), .imm_sign_o(imm_sign_o),
  .reg_we_o(reg_we_o), .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .branch_o(branch_o),
  .jump_o(jump_o), .muldiv_o(muldiv_o), .illegal_o(illegal_o)
);

// File: tb/tb_riscdec_top.sv
module tb_riscdec_top;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [31:0] instr_i;
  logic [1:0]  fmt_o, branch_o, jump_o;
  logic [4:0]  rs_o, rt_o, rd_o, shamt_o, dst_o;
  logic [15:0] imm_o;
  logic [31:0] imm_ext_o;
  logic [25:0] target_o;
  logic [2:0]  alu_op_o;
  logic imm_sign_o, reg_we_o, mem_rd_o, mem_wr_o, mem_byte_o, muldiv_o, illegal_o;

  riscdec_top dut (
    .instr_i(instr_i), .fmt_o(fmt_o), .rs_o(rs_o), .rt_o(rt_o), .rd_o(rd_o),
    .shamt_o(shamt_o), .imm_o(imm_o), .imm_ext_o(imm_ext_o), .target_o(target_o),
    .alu_op_o(alu_op_o), .dst_o(dst_o), .imm_sign_o(imm_sign_o), .reg_we_o(reg_we_o),
    .mem_rd_o(mem_rd_o), .mem_wr_o(mem_wr_o), .mem_byte_o(mem_byte_o),
    .branch_o(branch_o), .jump_o(jump_o), .muldiv_o(muldiv_o), .illegal_o(illegal_o)
  );

  typedef struct packed {
    logic [31:0] w;
    logic [3:0]  rq;
    logic [1:0]  fmt;
    logic [4:0]  dst;
    logic        we;
    logic [2:0]  alu;
    logic        sgn, mrd, mwr, byt;
    logic [1:0]  br, jmp;
    logic        md, ill;
  } vec_t;

  localparam int NV = 27;
  // fields: word, req, fmt, dst, we, alu, sgn, mrd, mwr, byte, br, jmp, md, ill
  localparam vec_t VEC [NV] = '{
    '{32'h014B4820, 4'd3,  2'd0, 5'd9,  1'b1, 3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R3 add
    '{32'h02328022, 4'd3,  2'd0, 5'd16, 1'b1, 3'd1, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R3 sub
    '{32'h012A4024, 4'd3,  2'd0, 5'd8,  1'b1, 3'd2, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R3 and
    '{32'h01CF8025, 4'd3,  2'd0, 5'd16, 1'b1, 3'd3, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R3 or
    '{32'h014B482A, 4'd3,  2'd0, 5'd9,  1'b1, 3'd4, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R3 slt
    '{32'h00850018, 4'd9,  2'd0, 5'd0,  1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1,1'b0}, // R9 mult
    '{32'h0085001A, 4'd9,  2'd0, 5'd0,  1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b1,1'b0}, // R9 div
    '{32'h03E00008, 4'd8,  2'd0, 5'd0,  1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd3, 1'b0,1'b0}, // R8 jr
    '{32'h014B0020, 4'd10, 2'd0, 5'd0,  1'b0, 3'd0, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R10 add to r0
    '{32'h014B4801, 4'd11, 2'd0, 5'd9,  1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1}, // R11 bad funct
    '{32'h21AC0043, 4'd4,  2'd1, 5'd12, 1'b1, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R4 addi
    '{32'h2129FFFF, 4'd5,  2'd1, 5'd9,  1'b1, 3'd0, 1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R5 addi neg
    '{32'h31288000, 4'd5,  2'd1, 5'd8,  1'b1, 3'd2, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R5 andi
    '{32'h373800FF, 4'd4,  2'd1, 5'd24, 1'b1, 3'd3, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R4 ori
    '{32'h29490005, 4'd4,  2'd1, 5'd9,  1'b1, 3'd4, 1'b1,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R4 slti
    '{32'h8D0B0000, 4'd6,  2'd1, 5'd11, 1'b1, 3'd0, 1'b1,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R6 lw
    '{32'hAD0A0008, 4'd6,  2'd1, 5'd10, 1'b0, 3'd0, 1'b1,1'b0,1'b1,1'b0, 2'd0,2'd0, 1'b0,1'b0}, // R6 sw
    '{32'h810B0004, 4'd6,  2'd1, 5'd11, 1'b1, 3'd0, 1'b1,1'b1,1'b0,1'b1, 2'd0,2'd0, 1'b0,1'b0}, // R6 lb
    '{32'hA10A0008, 4'd6,  2'd1, 5'd10, 1'b0, 3'd0, 1'b1,1'b0,1'b1,1'b1, 2'd0,2'd0, 1'b0,1'b0}, // R6 sb
    '{32'h11090002, 4'd7,  2'd1, 5'd9,  1'b0, 3'd1, 1'b1,1'b0,1'b0,1'b0, 2'd1,2'd0, 1'b0,1'b0}, // R7 beq
    '{32'h1611FFFE, 4'd7,  2'd1, 5'd17, 1'b0, 3'd1, 1'b1,1'b0,1'b0,1'b0, 2'd2,2'd0, 1'b0,1'b0}, // R7 bne
    '{32'h1D20FFF9, 4'd7,  2'd1, 5'd0,  1'b0, 3'd1, 1'b1,1'b0,1'b0,1'b0, 2'd3,2'd0, 1'b0,1'b0}, // R7 bgtz
    '{32'h08000029, 4'd8,  2'd2, 5'd0,  1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd1, 1'b0,1'b0}, // R8 j
    '{32'h0C000029, 4'd8,  2'd2, 5'd31, 1'b1, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd2, 1'b0,1'b0}, // R8 jal, R12 link dest
    '{32'h04000000, 4'd11, 2'd1, 5'd0,  1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1}, // R11 opcode 1
    '{32'hFC0A0000, 4'd11, 2'd1, 5'd10, 1'b0, 3'd5, 1'b0,1'b0,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b1}, // R11 opcode 63
    '{32'h8D000000, 4'd10, 2'd1, 5'd0,  1'b0, 3'd0, 1'b1,1'b1,1'b0,1'b0, 2'd0,2'd0, 1'b0,1'b0}  // R10 lw to r0
  };

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s word=%h actual=%h expected=%h", req, instr_i, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr_i = w;
    @(negedge clk);
  endtask

  initial begin
    instr_i = 32'h0;
    @(negedge clk);
    // R11: all-zero word (state seen right after start) is illegal and quiet
    chk("R11", {31'd0, illegal_o}, 32'd1);
    chk("R11", {27'd0, reg_we_o, mem_rd_o, mem_wr_o, muldiv_o, |jump_o}, 32'd0);
    // R2: all-zero word is register format
    chk("R2", {30'd0, fmt_o}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      vec_t act;
      apply(VEC[i].w);
      act = '{w: instr_i, rq: VEC[i].rq, fmt: fmt_o, dst: dst_o, we: reg_we_o, alu: alu_op_o,
              sgn: imm_sign_o, mrd: mem_rd_o, mwr: mem_wr_o, byt: mem_byte_o,
              br: branch_o, jmp: jump_o, md: muldiv_o, ill: illegal_o};
      n_chk++;
      if (act !== VEC[i]) begin
        n_bad++;
        $display("FAIL R%0d (R2/R12 fields) word=%h actual=%h expected=%h",
                 VEC[i].rq, VEC[i].w, act[27:0], VEC[i][27:0]);
      end
    end

    // R1: raw fields with every bit set
    apply(32'hFFFFFFFF);
    chk("R1", {27'd0, rs_o}, 32'd31);
    chk("R1", {27'd0, rt_o}, 32'd31);
    chk("R1", {27'd0, rd_o}, 32'd31);
    chk("R1", {27'd0, shamt_o}, 32'd31);
    chk("R1", {16'd0, imm_o}, 32'h0000FFFF);
    chk("R1", {6'd0, target_o}, 32'h03FFFFFF);
    // R1: distinct field values
    apply(32'h014B4AA0);
    chk("R1", {7'd0, rs_o, rt_o, rd_o, shamt_o}, {7'd0, 5'd10, 5'd11, 5'd9, 5'd10});
    chk("R1", {6'd0, target_o}, 32'h014B4AA0);
    // R5: extension results
    apply(32'h2129FFFF);
    chk("R5", imm_ext_o, 32'hFFFFFFFF);
    apply(32'h31288000);
    chk("R5", imm_ext_o, 32'h00008000);
    apply(32'h1611FFFE);
    chk("R5", imm_ext_o, 32'hFFFFFFFE);
    apply(32'h373880FF);
    chk("R5", imm_ext_o, 32'h000080FF);
    // R12: jump with nonzero register bits still names no destination
    apply(32'h0BFFFFFF);
    chk("R12", {27'd0, dst_o}, 32'd0);
    chk("R8", {30'd0, jump_o}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule